// File: doc/BRIEF.md
# ISA Bus Cycle Sequencer

This block sits between a small 8-bit host and an 8-bit ISA expansion bus. It turns a single-clock host access that lands in an ISA window into a separate ISA bus cycle that runs at the card's own pace. The host access itself only records the request: the direction, the memory-or-I/O selector (ISA address bit 8), the low address byte and, for writes, the data byte. The ISA cycle begins only when the host's instruction-fetch marker shows that the current instruction is complete. This matters because an indexed instruction first puts its un-indexed address on the bus and then the real one. Because the latest hit before the fetch is the one that runs, the early false hit is overwritten and never reaches the bus.

Each ISA cycle drives one active-low strobe (memory read, memory write, I/O read or I/O write). The strobe is lengthened by one clock for every clock in which the card holds the ready line low. A recovery clock with a one-clock clear pulse follows. Read data is parked in a holding register when the strobe ends, and the host fetches it with a later, separate access. The block also holds an interrupt latch. Six active-high ISA request lines are synchronised and combined by OR. A rising edge of that OR sets the latch. Any ISA read strobe clears it. While the latch is set, it drives an active-low host interrupt.

Top module: `isa_cycle_seq`

## Requirements
- R1: While `rst` is high, all four strobes are high, `busy`, `isa_clr` and `isa_wdata_oe` are 0, `irq_n` is 1, `irq_flag` is 0 and `rd_hold` is 0.
- R2: A `win_hit` in idle records the request but starts no strobe until `fetch_sync` is seen high in a later clock. When several hits come before that fetch, the last one sets the direction, selector, address and data of the cycle.
- R3: The strobe of a cycle depends on `host_wr` (1 = write) and `addr_b8` (1 = memory): write with 1 gives `isa_memw_n`, write with 0 gives `isa_iow_n`, read with 1 gives `isa_memr_n`, read with 0 gives `isa_ior_n`. The other three strobes stay high, and `isa_addr_lo` shows the recorded address during the strobe.
- R4: A strobe goes low on the clock edge that samples `fetch_sync` high and lasts 1 + k clocks, where k is the number of consecutive strobe-state clock edges that sample `isa_rdy` low.
- R5: After the strobe, one recovery clock follows with all strobes high and `isa_clr` high, and then the block is idle with `isa_clr` low. `busy` is high from the first strobe clock through the recovery clock.
- R6: `isa_wdata_oe` is high exactly while a write strobe is low, and `isa_wdata` then carries the recorded write byte.
- R7: At the edge that ends a read strobe, `isa_rdata` is stored into `rd_hold`. It stays there through later write cycles until the next read.
- R8: A `win_hit` while `busy` is high, or in the same clock in which a cycle starts, is dropped: it changes neither the running cycle nor any later one.
- R9: A rising edge of the OR of `isa_req` sets `irq_flag` three clock edges after the line rises. A further line rising while the OR is already high does not set it again. `irq_n` is the inverse of `irq_flag`.
- R10: `irq_flag` is cleared by a clock in which `isa_memr_n` or `isa_ior_n` is low. Write strobes leave it set.
- R11: When an interrupt edge and a clearing read strobe fall in the same clock, the flag ends set.
- R12: `isa_reset` is `rst` delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_hit | input | 1 | One-clock strobe: host access in the ISA window |
| host_wr | input | 1 | Host direction, 1 = write |
| fetch_sync | input | 1 | High during a host instruction-fetch clock |
| addr_b8 | input | 1 | ISA address bit 8, 1 = memory, 0 = I/O |
| host_addr_lo | input | ADDR_W | Low ISA address byte of the access |
| host_wdata | input | DATA_W | Host write data |
| isa_rdy | input | 1 | ISA ready, low requests a wait state |
| isa_rdata | input | DATA_W | Data from the ISA bus |
| isa_req | input | N_REQ | Active-high ISA interrupt requests |
| isa_memr_n | output | 1 | Memory read strobe, active low |
| isa_memw_n | output | 1 | Memory write strobe, active low |
| isa_ior_n | output | 1 | I/O read strobe, active low |
| isa_iow_n | output | 1 | I/O write strobe, active low |
| isa_addr_lo | output | ADDR_W | Recorded low address byte |
| isa_wdata | output | DATA_W | Recorded write byte |
| isa_wdata_oe | output | 1 | Drive enable for isa_wdata |
| isa_clr | output | 1 | One-clock clear pulse in recovery |
| rd_hold | output | DATA_W | Parked read data for the host |
| irq_n | output | 1 | Host interrupt, active low |
| irq_flag | output | 1 | Interrupt latch state for host status |
| isa_reset | output | 1 | Active-high ISA bus reset |
| busy | output | 1 | ISA cycle in progress |

## Verification
The interrupt latch has two functions that can meet in one clock: setting on a new request edge and clearing on a read strobe. The bench provokes this by raising a request line in the same clock as the window hit and asserting the fetch marker one clock later, with ready held high. The one-clock read strobe then spans exactly the clock in which the synchronised edge reaches the latch, and the flag must read 1 afterwards. A plain read with no coinciding edge is run earlier and must leave it at 0. A second collision, a window hit in the same clock as the fetch that starts a cycle, is checked by confirming that the running cycle keeps its recorded address and that no cycle follows a later fetch.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_STROBE = 2'd1,
      ST_RECOV  = 2'd2,
      ST_SPARE  = 2'd3
   } seq_state_e;

   // active-high internal view of the four bus strobes
   typedef struct packed {
      logic memr;
      logic memw;
      logic ior;
      logic iow;
   } strobe_t;

   function automatic strobe_t pick_strobe(input logic is_wr, input logic is_mem);
      strobe_t s;
      s.memr = !is_wr &&  is_mem;
      s.memw =  is_wr &&  is_mem;
      s.ior  = !is_wr && !is_mem;
      s.iow  =  is_wr && !is_mem;
      return s;
   endfunction

endpackage

// File: rtl/isa_req_capture.sv
module isa_req_capture #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              win_hit,
   input  logic              host_wr,
   input  logic              addr_b8,
   input  logic [ADDR_W-1:0] host_addr_lo,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              idle,
   input  logic              start,
   output logic              armed,
   output logic              cap_wr,
   output logic              cap_mem,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data
);

   logic take;
   assign take = win_hit && idle && !start;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed    <= 1'b0;
         cap_wr   <= 1'b0;
         cap_mem  <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         if (start)
            armed <= 1'b0;
         else if (take)
            armed <= 1'b1;
         if (take) begin
            cap_wr   <= host_wr;
            cap_mem  <= addr_b8;
            cap_addr <= host_addr_lo;
            cap_data <= host_wdata;
         end
      end
   end

   // R8: a hit outside idle leaves the recorded request alone
   assert_busy_hit_dropped_R8: assert property (@(posedge clk) disable iff (rst)
      (win_hit && !idle) |=> ($stable(cap_addr) && $stable(cap_wr) && $stable(cap_data)));

   // R2: the request stays pending until a start consumes it
   assert_armed_kept_R2: assert property (@(posedge clk) disable iff (rst)
      (armed && !start) |=> armed);

endmodule

// File: rtl/isa_strobe_fsm.sv
module isa_strobe_fsm
   import isa_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    armed,
   input  logic    fetch_sync,
   input  logic    isa_rdy,
   input  logic    cap_wr,
   input  logic    cap_mem,
   output logic    start,
   output logic    idle,
   output logic    busy,
   output logic    rd_done,
   output strobe_t strobe_q,
   output logic    wr_oe_q,
   output logic    clr_q
);

   seq_state_e st_q, st_d;

   assign idle    = (st_q == ST_IDLE);
   assign start   = idle && armed && fetch_sync;
   assign busy    = !idle;
   assign rd_done = (st_q == ST_STROBE) && isa_rdy && !cap_wr;

   always_comb begin
      case (st_q)
         ST_IDLE:   st_d = start ? ST_STROBE : ST_IDLE;
         ST_STROBE: st_d = isa_rdy ? ST_RECOV : ST_STROBE;
         ST_RECOV:  st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         strobe_q <= '0;
         wr_oe_q  <= 1'b0;
         clr_q    <= 1'b0;
      end else begin
         st_q     <= st_d;
         strobe_q <= (st_d == ST_STROBE) ? pick_strobe(cap_wr, cap_mem) : '0;
         wr_oe_q  <= (st_d == ST_STROBE) && cap_wr;
         clr_q    <= (st_d == ST_RECOV);
      end
   end

   logic [3:0] strobe_vec;
   assign strobe_vec = strobe_q;

   assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(strobe_vec));

   assert_wait_stretch_R4: assert property (@(posedge clk) disable iff (rst)
      ((st_q == ST_STROBE) && !isa_rdy) |=> ($stable(strobe_vec) && (strobe_vec != 4'd0)));

   assert_recovery_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      clr_q |-> (strobe_vec == 4'd0));

   assert_recovery_ends_R5: assert property (@(posedge clk) disable iff (rst)
      clr_q |=> (idle && !clr_q));

   assert_wait_for_fetch_R2: assert property (@(posedge clk) disable iff (rst)
      (idle && !fetch_sync) |=> (strobe_vec == 4'd0));

   assert_oe_with_write_R6: assert property (@(posedge clk) disable iff (rst)
      wr_oe_q |-> (strobe_q.memw || strobe_q.iow));

   assert_no_spare_state: assert property (@(posedge clk) disable iff (rst)
      st_q != ST_SPARE);

endmodule

// File: rtl/isa_read_hold.sv
module isa_read_hold #(
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] bus_data,
   output logic [DATA_W-1:0] hold_q
);

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= RESET_VAL;
      else if (load)
         hold_q <= bus_data;
   end

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(hold_q));

endmodule

// File: rtl/isa_irq_latch.sv
module isa_irq_latch #(
   parameter int N_REQ       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_REQ-1:0] req,
   input  logic             rd_strobe,
   output logic             flag_q
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("isa_irq_latch: SYNC_STAGES must be at least 2");
   end

   logic [N_REQ-1:0] stage_q [SYNC_STAGES];

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
         if (rst)
            stage_q[i] <= '0;
         else if (i == 0)
            stage_q[i] <= req;
         else
            stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
   end

   logic any_now, any_prev_q, set_ev;
   assign any_now = |stage_q[LAST];
   assign set_ev  = any_now && !any_prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         any_prev_q <= 1'b0;
         flag_q     <= 1'b0;
      end else begin
         any_prev_q <= any_now;
         if (set_ev)
            flag_q <= 1'b1;
         else if (rd_strobe)
            flag_q <= 1'b0;
      end
   end

   assert_edge_sets_R9: assert property (@(posedge clk) disable iff (rst)
      set_ev |=> flag_q);

   assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
      (rd_strobe && !set_ev) |=> !flag_q);

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
      (rd_strobe && set_ev) |=> flag_q);

   assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
      (!rd_strobe && !set_ev) |=> $stable(flag_q));

endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
   import isa_seq_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int N_REQ       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              win_hit,
   input  logic              host_wr,
   input  logic              fetch_sync,
   input  logic              addr_b8,
   input  logic [ADDR_W-1:0] host_addr_lo,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              isa_rdy,
   input  logic [DATA_W-1:0] isa_rdata,
   input  logic [N_REQ-1:0]  isa_req,
   output logic              isa_memr_n,
   output logic              isa_memw_n,
   output logic              isa_ior_n,
   output logic              isa_iow_n,
   output logic [ADDR_W-1:0] isa_addr_lo,
   output logic [DATA_W-1:0] isa_wdata,
   output logic              isa_wdata_oe,
   output logic              isa_clr,
   output logic [DATA_W-1:0] rd_hold,
   output logic              irq_n,
   output logic              irq_flag,
   output logic              isa_reset,
   output logic              busy
);

   if (ADDR_W < 1 || DATA_W < 1 || N_REQ < 1) begin : g_bad_width
      $error("isa_cycle_seq: widths and request count must be positive");
   end

   logic    armed, cap_wr, cap_mem, start, idle, rd_done;
   strobe_t strobe_q;
   logic    rst_d_q;

   isa_req_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
      .clk(clk), .rst(rst), .win_hit(win_hit), .host_wr(host_wr),
      .addr_b8(addr_b8), .host_addr_lo(host_addr_lo), .host_wdata(host_wdata),
      .idle(idle), .start(start), .armed(armed), .cap_wr(cap_wr),
      .cap_mem(cap_mem), .cap_addr(isa_addr_lo), .cap_data(isa_wdata)
   );

   isa_strobe_fsm u_fsm (
      .clk(clk), .rst(rst), .armed(armed), .fetch_sync(fetch_sync),
      .isa_rdy(isa_rdy), .cap_wr(cap_wr), .cap_mem(cap_mem), .start(start),
      .idle(idle), .busy(busy), .rd_done(rd_done), .strobe_q(strobe_q),
      .wr_oe_q(isa_wdata_oe), .clr_q(isa_clr)
   );

   isa_read_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst(rst), .load(rd_done), .bus_data(isa_rdata), .hold_q(rd_hold)
   );

   isa_irq_latch #(.N_REQ(N_REQ), .SYNC_STAGES(SYNC_STAGES)) u_irq (
      .clk(clk), .rst(rst), .req(isa_req),
      .rd_strobe(strobe_q.memr || strobe_q.ior), .flag_q(irq_flag)
   );

   always_ff @(posedge clk) rst_d_q <= rst;

   assign isa_memr_n = !strobe_q.memr;
   assign isa_memw_n = !strobe_q.memw;
   assign isa_ior_n  = !strobe_q.ior;
   assign isa_iow_n  = !strobe_q.iow;
   assign irq_n      = !irq_flag;
   assign isa_reset  = rst_d_q;

   assert_bus_reset_R12: assert property (@(posedge clk)
      rst |=> isa_reset);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (isa_memr_n && isa_memw_n && isa_ior_n && isa_iow_n && !busy && irq_n));

endmodule

// File: tb/isa_cycle_seq_bench.sv
`timescale 1ns/1ps
module isa_cycle_seq_bench;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst = 1'b1, win_hit = 1'b0, host_wr = 1'b0, fetch_sync = 1'b0;
   logic       addr_b8 = 1'b0, isa_rdy = 1'b1;
   logic [7:0] host_addr_lo = '0, host_wdata = '0, isa_rdata = '0;
   logic [5:0] isa_req = '0;
   logic       isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n, isa_wdata_oe, isa_clr;
   logic [7:0] isa_addr_lo, isa_wdata, rd_hold;
   logic       irq_n, irq_flag, isa_reset, busy;

   isa_cycle_seq u_isa_cycle_seq (.*);

   int  checks = 0, errors = 0;
   bit  ended = 1'b0;

   function automatic logic [3:0] strobes();
      return {~isa_memr_n, ~isa_memw_n, ~isa_ior_n, ~isa_iow_n};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic nclk(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic arm(input bit wr, input bit mem, input logic [7:0] a, input logic [7:0] d);
      win_hit = 1'b1; host_wr = wr; addr_b8 = mem; host_addr_lo = a; host_wdata = d;
      nclk();
      win_hit = 1'b0;
   endtask

   // raises fetch, runs the cycle, returns strobe mask, strobe length and a data-path flag
   task automatic fire(input bit wr, input logic [7:0] a, input logic [7:0] d, input int waits,
                       input bit mid_hit, input bit coin_hit,
                       output logic [3:0] mask, output int len, output bit path_ok);
      int j = 2;
      mask = '0; len = 0; path_ok = 1'b1;
      fetch_sync = 1'b1; isa_rdy = (waits == 0);
      if (coin_hit) begin
         win_hit = 1'b1; host_addr_lo = 8'hC3; host_wr = ~wr;
      end
      nclk();
      fetch_sync = 1'b0; win_hit = 1'b0;
      while (strobes() != 4'd0 && len < 60) begin
         mask |= strobes();
         len++;
         if (isa_addr_lo !== a) path_ok = 1'b0;
         if (wr && (isa_wdata_oe !== 1'b1 || isa_wdata !== d)) path_ok = 1'b0;
         if (!wr && isa_wdata_oe !== 1'b0) path_ok = 1'b0;
         if (mid_hit && len == 1) begin
            win_hit = 1'b1; host_addr_lo = 8'hEE; host_wr = ~wr;
         end else
            win_hit = 1'b0;
         isa_rdy = (j > waits + 1);
         nclk();
         j++;
      end
      win_hit = 1'b0;
      chk("R5 clear pulse in recovery", {isa_clr, busy, strobes()}, {1'b1, 1'b1, 4'd0});
      nclk();
      chk("R5 idle after recovery", {isa_clr, busy}, 2'b00);
      isa_rdy = 1'b1;
   endtask

   task automatic expect_no_cycle(input string req);
      fetch_sync = 1'b1; nclk(); fetch_sync = 1'b0;
      chk(req, {busy, strobes()}, 5'd0);
      nclk();
      chk(req, {busy, strobes()}, 5'd0);
   endtask

   task automatic t_reset();
      nclk(3);
      chk("R1 reset outputs", {strobes(), busy, isa_clr, isa_wdata_oe, irq_n, irq_flag},
          {4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
      chk("R1 reset hold", rd_hold, 8'h00);
      chk("R12 bus reset high", isa_reset, 1'b1);
      rst = 1'b0;
      nclk(2);
      chk("R12 bus reset released", isa_reset, 1'b0);
   endtask

   task automatic t_decode();
      logic [3:0] m; int len; bit ok;
      arm(1, 0, 8'h21, 8'hA5); fire(1, 8'h21, 8'hA5, 0, 0, 0, m, len, ok);
      chk("R3 io write strobe", m, 4'b0001); chk("R6 io write data", ok, 1'b1);
      chk("R4 single clock strobe", len, 1);
      arm(1, 1, 8'h42, 8'h3C); fire(1, 8'h42, 8'h3C, 0, 0, 0, m, len, ok);
      chk("R3 mem write strobe", m, 4'b0100); chk("R6 mem write data", ok, 1'b1);
      isa_rdata = 8'h96;
      arm(0, 0, 8'h63, 8'h00); fire(0, 8'h63, 8'h00, 0, 0, 0, m, len, ok);
      chk("R3 io read strobe", m, 4'b0010); chk("R6 no oe on read", ok, 1'b1);
      chk("R7 io read parked", rd_hold, 8'h96);
      isa_rdata = 8'h5A;
      arm(0, 1, 8'h84, 8'h00); fire(0, 8'h84, 8'h00, 0, 0, 0, m, len, ok);
      chk("R3 mem read strobe", m, 4'b1000);
      chk("R7 mem read parked", rd_hold, 8'h5A);
   endtask

   task automatic t_waits();
      logic [3:0] m; int len; bit ok;
      isa_rdata = 8'h71;
      arm(0, 0, 8'h10, 8'h00); fire(0, 8'h10, 8'h00, 3, 0, 0, m, len, ok);
      chk("R4 three wait states", len, 4);
      chk("R7 read after waits", rd_hold, 8'h71);
      isa_rdata = 8'hFF;
      arm(1, 1, 8'h11, 8'h2B); fire(1, 8'h11, 8'h2B, 2, 0, 0, m, len, ok);
      chk("R4 write with two waits", len, 3);
      chk("R6 data held through waits", ok, 1'b1);
      chk("R7 hold unchanged by write", rd_hold, 8'h71);
   endtask

   task automatic t_deferred();
      logic [3:0] m; int len; bit ok;
      arm(1, 0, 8'h99, 8'h01);
      nclk(3);
      chk("R2 no strobe before fetch", {busy, strobes()}, 5'd0);
      arm(0, 1, 8'h22, 8'h00);
      fire(0, 8'h22, 8'h00, 0, 0, 0, m, len, ok);
      chk("R2 latest hit wins", {m, ok}, {4'b1000, 1'b1});
   endtask

   task automatic t_busy_hits();
      logic [3:0] m; int len; bit ok;
      arm(0, 0, 8'h35, 8'h00); fire(0, 8'h35, 8'h00, 3, 1, 0, m, len, ok);
      chk("R8 busy hit keeps cycle", {m, ok, len}, {4'b0010, 1'b1, 32'd4});
      expect_no_cycle("R8 busy hit not replayed");
      arm(1, 0, 8'h36, 8'h44); fire(1, 8'h36, 8'h44, 0, 0, 1, m, len, ok);
      chk("R8 coincident hit keeps cycle", {m, ok}, {4'b0001, 1'b1});
      expect_no_cycle("R8 coincident hit not replayed");
   endtask

   task automatic t_irq();
      logic [3:0] m; int len; bit ok;
      isa_req[3] = 1'b1;
      nclk(2);
      chk("R9 flag not yet set", irq_flag, 1'b0);
      nclk();
      chk("R9 flag set on third edge", {irq_flag, irq_n}, 2'b10);
      isa_req[0] = 1'b1;
      arm(1, 1, 8'h50, 8'h07); fire(1, 8'h50, 8'h07, 1, 0, 0, m, len, ok);
      chk("R10 write keeps flag", irq_flag, 1'b1);
      arm(0, 1, 8'h51, 8'h00); fire(0, 8'h51, 8'h00, 0, 0, 0, m, len, ok);
      chk("R10 read clears flag", {irq_flag, irq_n}, 2'b01);
      isa_req[5] = 1'b1;
      nclk(5);
      chk("R9 no set while OR high", irq_flag, 1'b0);
      isa_req = '0;
      nclk(4);
   endtask

   task automatic t_set_wins();
      logic [3:0] m; int len; bit ok;
      isa_req[5] = 1'b1; nclk(4);
      chk("R9 flag set again", irq_flag, 1'b1);
      isa_req = '0; nclk(4);
      chk("R9 falling edge no effect", irq_flag, 1'b1);
      isa_req[1] = 1'b1;
      arm(0, 0, 8'h77, 8'h00);
      fire(0, 8'h77, 8'h00, 0, 0, 0, m, len, ok);
      chk("R11 set wins over read clear", {irq_flag, m}, {1'b1, 4'b0010});
   endtask

   initial begin
      #(4 * 20000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_decode();
      t_waits();
      t_deferred();
      t_busy_hits();
      t_irq();
      t_set_wins();
      nclk(2);
      finish_run();
   end

endmodule